// File: doc/BRIEF.md
# Paged Memory Window Mapper

This block sits between a host memory bus and a removable memory card. It holds five programmable windows. Each window claims a range of host pages, 4 KiB each, and moves every access inside that range to a card page found by adding a per-window page offset. Each window also carries its own access attributes: data path width, a zero-wait request, a wait-state count, a choice between attribute and common card memory, and a write protect.

Software programs the windows through a byte-wide register port. Each window has six bytes. The host page bounds and the card offset are split across a low byte and the low bits of a high byte. The spare high bits of those bytes hold the attribute flags. One separate byte holds a per-window enable bit. The host side issues a request with a 24-bit address and a write flag. One clock later the block reports exactly one outcome: a card strobe with the translated 26-bit card address and the attributes, a blocked write, or a miss.

Top module: `mwm_mapper`

## Requirements
- R1: After reset every register byte reads 0, so every window is disabled and a host request gives `no_claim`.
- R2: A byte written on the register port reads back from the next cycle. The enable byte is at 0x06, and bit i enables window i. Window i owns bytes 0x10+8*i+k for k = 0..5: k=0 start low, k=1 start high, k=2 stop low, k=3 stop high, k=4 offset low, k=5 offset high. Enable bits at or above the window count, and all other addresses, read 0.
- R3: Window i matches when its enable bit is set and start <= page <= stop. The page is host_addr[23:12]. Start is {start high[3:0], start low}, and stop is formed the same way from the stop bytes. Both bounds are inclusive.
- R4: When several windows match, the lowest-numbered one is used.
- R5: The card address is {(page + offset) mod 2^14, host_addr[11:0]}, where the offset is {offset high[5:0], offset low}.
- R6: On a strobe, `card_attr` = offset high bit 6, `card_wide` = start high bit 7, `card_zero_wait` = start high bit 6 and `card_waits` = stop high bits 7:6. Start high bits 5:4 are scratch bits that read back and have no effect.
- R7: A write that selects a window with offset high bit 7 set gives no card strobe and raises `wr_blocked` for one cycle. A read from such a window strobes as normal.
- R8: Every outcome appears on the cycle after the request and lasts one cycle. At most one of `card_strobe`, `no_claim` and `wr_blocked` is high. A request that no window matches gives `no_claim`.
- R9: A window whose enable bit is clear never matches, whatever its bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| host_req | input | 1 | Host access request, one cycle |
| host_wr | input | 1 | Host access is a write |
| host_addr | input | 24 | Host byte address |
| card_strobe | output | 1 | Access passed to the card |
| card_wr | output | 1 | Passed access is a write |
| card_addr | output | 26 | Translated card byte address |
| card_attr | output | 1 | 1 = attribute memory, 0 = common memory |
| card_wide | output | 1 | 1 = 16-bit data path, 0 = 8-bit |
| card_zero_wait | output | 1 | Zero-wait access requested |
| card_waits | output | 2 | Wait-state count 0..3 |
| no_claim | output | 1 | No enabled window matched |
| wr_blocked | output | 1 | Write refused by write protect |

## Verification
The assertions check the outcome rules on every cycle. They check that the strobe, miss and blocked flags are mutually exclusive and follow a request by exactly one cycle. They also check that a blocked flag or a card write only follows a host write, and that the low 12 address bits pass through unchanged. Only the bench scenarios can show the translation itself. That covers inclusive bounds at both ends, the lowest-index choice in an overlap, the offset wrap past 2^14 pages, the flag decoding from the shared bytes, a disabled window that stays silent, and register readback.

// File: rtl/mwm_pkg.sv
package mwm_pkg;
   localparam int PG_SHIFT = 12;                 // 4 KiB pages
   localparam int HPG_W    = 12;                 // host page bits
   localparam int CPG_W    = 14;                 // card page bits
   localparam int HOST_AW  = HPG_W + PG_SHIFT;
   localparam int CARD_AW  = CPG_W + PG_SHIFT;
   localparam int BYTE_W   = 8;
   localparam int GRP_REGS = 6;                  // bytes per window

   typedef struct packed {
      logic             en;
      logic [HPG_W-1:0] start;
      logic [HPG_W-1:0] stop;
      logic [CPG_W-1:0] offs;
      logic             wide;
      logic             zws;
      logic [1:0]       waits;
      logic             wp;
      logic             attr;
   } win_cfg_t;
endpackage

// File: rtl/mwm_regfile.sv
module mwm_regfile
   import mwm_pkg::*;
#(
   parameter int NUM_WIN    = 5,
   parameter int REG_AW     = 8,
   parameter int EN_ADDR    = 'h06,
   parameter int GRP_BASE   = 'h10,
   parameter int GRP_STRIDE = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_we,
   input  logic [REG_AW-1:0]          reg_addr,
   input  logic [BYTE_W-1:0]          reg_wdata,
   output logic [BYTE_W-1:0]          reg_rdata,
   output win_cfg_t [NUM_WIN-1:0]     cfg_o
);
   localparam int HI_LOW_W = HPG_W - BYTE_W;     // page bits kept in high byte
   localparam int OF_LOW_W = CPG_W - BYTE_W;     // offset bits kept in high byte

   logic [BYTE_W-1:0]  grp_q [NUM_WIN][GRP_REGS];
   logic [NUM_WIN-1:0] en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= '0;
      else if (reg_we && reg_addr == REG_AW'(EN_ADDR)) en_q <= reg_wdata[NUM_WIN-1:0];
   end

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      for (genvar b = 0; b < GRP_REGS; b++) begin : g_byte
         localparam logic [REG_AW-1:0] BYTE_ADDR = REG_AW'(GRP_BASE + w*GRP_STRIDE + b);
         always_ff @(posedge clk) begin
            if (!rst_n) grp_q[w][b] <= '0;
            else if (reg_we && reg_addr == BYTE_ADDR) grp_q[w][b] <= reg_wdata;
         end
      end
      assign cfg_o[w].en    = en_q[w];
      assign cfg_o[w].start = {grp_q[w][1][HI_LOW_W-1:0], grp_q[w][0]};
      assign cfg_o[w].stop  = {grp_q[w][3][HI_LOW_W-1:0], grp_q[w][2]};
      assign cfg_o[w].offs  = {grp_q[w][5][OF_LOW_W-1:0], grp_q[w][4]};
      assign cfg_o[w].wide  = grp_q[w][1][7];
      assign cfg_o[w].zws   = grp_q[w][1][6];
      assign cfg_o[w].waits = grp_q[w][3][7:6];
      assign cfg_o[w].wp    = grp_q[w][5][7];
      assign cfg_o[w].attr  = grp_q[w][5][6];
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(EN_ADDR)) reg_rdata[NUM_WIN-1:0] = en_q;
      for (int w = 0; w < NUM_WIN; w++) begin
         for (int b = 0; b < GRP_REGS; b++) begin
            if (reg_addr == REG_AW'(GRP_BASE + w*GRP_STRIDE + b)) reg_rdata = grp_q[w][b];
         end
      end
   end
endmodule

// File: rtl/mwm_win_match.sv
module mwm_win_match
   import mwm_pkg::*;
(
   input  win_cfg_t         cfg,
   input  logic [HPG_W-1:0] host_pg,
   output logic             hit,
   output logic [CPG_W-1:0] card_pg
);
   assign hit     = cfg.en && (host_pg >= cfg.start) && (host_pg <= cfg.stop);
   assign card_pg = CPG_W'(host_pg) + cfg.offs;   // wraps modulo 2^CPG_W
endmodule

// File: rtl/mwm_prio_sel.sv
module mwm_prio_sel
   import mwm_pkg::*;
#(
   parameter int NUM_WIN = 5
) (
   input  logic [NUM_WIN-1:0]              hit,
   input  win_cfg_t [NUM_WIN-1:0]          cfg,
   input  logic [NUM_WIN-1:0][CPG_W-1:0]   card_pg,
   output logic                            any,
   output win_cfg_t                        sel_cfg,
   output logic [CPG_W-1:0]                sel_pg
);
   always_comb begin
      any     = |hit;
      sel_cfg = '0;
      sel_pg  = '0;
      // walk downward so the lowest matching index is written last
      for (int w = NUM_WIN-1; w >= 0; w--) begin
         if (hit[w]) begin
            sel_cfg = cfg[w];
            sel_pg  = card_pg[w];
         end
      end
   end
endmodule

// File: rtl/mwm_mapper.sv
module mwm_mapper
   import mwm_pkg::*;
#(
   parameter int NUM_WIN    = 5,
   parameter int REG_AW     = 8,
   parameter int EN_ADDR    = 'h06,
   parameter int GRP_BASE   = 'h10,
   parameter int GRP_STRIDE = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [7:0]         reg_addr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   input  logic               host_req,
   input  logic               host_wr,
   input  logic [23:0]        host_addr,
   output logic               card_strobe,
   output logic               card_wr,
   output logic [25:0]        card_addr,
   output logic               card_attr,
   output logic               card_wide,
   output logic               card_zero_wait,
   output logic [1:0]         card_waits,
   output logic               no_claim,
   output logic               wr_blocked
);
   if (NUM_WIN < 1 || NUM_WIN > BYTE_W) begin : g_bad_count
      $error("NUM_WIN must fit the one-byte enable register");
   end
   if (GRP_STRIDE < GRP_REGS) begin : g_bad_stride
      $error("GRP_STRIDE smaller than the bytes of one window");
   end
   if (REG_AW != BYTE_W || HOST_AW != 24 || CARD_AW != 26) begin : g_bad_width
      $error("port widths disagree with package layout");
   end

   win_cfg_t [NUM_WIN-1:0]            cfg;
   logic [NUM_WIN-1:0]                hit;
   logic [NUM_WIN-1:0][CPG_W-1:0]     cpg;
   logic                              any;
   win_cfg_t                          sel_cfg;
   logic [CPG_W-1:0]                  sel_pg;
   logic [HPG_W-1:0]                  host_pg;

   assign host_pg = host_addr[HOST_AW-1:PG_SHIFT];

   mwm_regfile #(
      .NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .EN_ADDR(EN_ADDR),
      .GRP_BASE(GRP_BASE), .GRP_STRIDE(GRP_STRIDE)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_o(cfg)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
      mwm_win_match match_i (
         .cfg(cfg[w]), .host_pg(host_pg), .hit(hit[w]), .card_pg(cpg[w])
      );
   end

   mwm_prio_sel #(.NUM_WIN(NUM_WIN)) sel_i (
      .hit(hit), .cfg(cfg), .card_pg(cpg),
      .any(any), .sel_cfg(sel_cfg), .sel_pg(sel_pg)
   );

   logic claim, refuse;
   assign claim  = host_req && any;
   assign refuse = claim && host_wr && sel_cfg.wp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         card_strobe    <= 1'b0;
         card_wr        <= 1'b0;
         card_addr      <= '0;
         card_attr      <= 1'b0;
         card_wide      <= 1'b0;
         card_zero_wait <= 1'b0;
         card_waits     <= '0;
         no_claim       <= 1'b0;
         wr_blocked     <= 1'b0;
      end else begin
         card_strobe <= claim && !refuse;
         card_wr     <= claim && !refuse && host_wr;
         no_claim    <= host_req && !any;
         wr_blocked  <= refuse;
         if (claim) begin
            card_addr      <= {sel_pg, host_addr[PG_SHIFT-1:0]};
            card_attr      <= sel_cfg.attr;
            card_wide      <= sel_cfg.wide;
            card_zero_wait <= sel_cfg.zws;
            card_waits     <= sel_cfg.waits;
         end
      end
   end
endmodule

// File: rtl/mwm_mapper_chk.sv
module mwm_mapper_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        host_req,
   input logic        host_wr,
   input logic [23:0] host_addr,
   input logic        card_strobe,
   input logic        card_wr,
   input logic [25:0] card_addr,
   input logic        no_claim,
   input logic        wr_blocked
);
   // R8
   outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({card_strobe, no_claim, wr_blocked}));

   // R8
   outcome_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (card_strobe || no_claim || wr_blocked) == $past(host_req));

   // R7
   blk_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_blocked |-> $past(host_req && host_wr));

   // R7
   card_wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_wr |-> (card_strobe && $past(host_wr)));

   // R5
   low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_strobe |-> (card_addr[11:0] == $past(host_addr[11:0])));
endmodule

bind mwm_mapper mwm_mapper_chk chk_i (
   .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
   .host_addr(host_addr), .card_strobe(card_strobe), .card_wr(card_wr),
   .card_addr(card_addr), .no_claim(no_claim), .wr_blocked(wr_blocked)
);

// File: tb/mwm_mapper_tb.sv
module mwm_mapper_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        host_req = 1'b0;
   logic        host_wr = 1'b0;
   logic [23:0] host_addr = '0;
   logic        card_strobe, card_wr, card_attr, card_wide, card_zero_wait;
   logic [25:0] card_addr;
   logic [1:0]  card_waits;
   logic        no_claim, wr_blocked;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   mwm_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_req(host_req),
      .host_wr(host_wr), .host_addr(host_addr), .card_strobe(card_strobe),
      .card_wr(card_wr), .card_addr(card_addr), .card_attr(card_attr),
      .card_wide(card_wide), .card_zero_wait(card_zero_wait),
      .card_waits(card_waits), .no_claim(no_claim), .wr_blocked(wr_blocked)
   );

   typedef struct packed {
      logic        wr;
      logic [23:0] addr;
      logic        strobe;
      logic        miss;
      logic        blk;
      logic [25:0] caddr;
      logic        attr;
      logic        wide;
      logic        zws;
      logic [1:0]  waits;
   } vec_t;

   // windows: W0 pages 100..1FF off 3F00 (wraps), W1 180..280 off 0010 wp attr,
   // W2 800..800 disabled, W4 FFF..FFF off 3000 attr
   localparam int NVEC = 11;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 24'h100ABC, 1'b1, 1'b0, 1'b0, 26'h0000ABC, 1'b0, 1'b1, 1'b0, 2'd2},  // R3 R5 wrap
      '{1'b0, 24'h1FF123, 1'b1, 1'b0, 1'b0, 26'h00FF123, 1'b0, 1'b1, 1'b0, 2'd2},  // R3 stop bound
      '{1'b0, 24'h0FFFFF, 1'b0, 1'b1, 1'b0, 26'h0,       1'b0, 1'b0, 1'b0, 2'd0},  // R8 miss below
      '{1'b0, 24'h180000, 1'b1, 1'b0, 1'b0, 26'h0080000, 1'b0, 1'b1, 1'b0, 2'd2},  // R4 overlap
      '{1'b1, 24'h180000, 1'b1, 1'b0, 1'b0, 26'h0080000, 1'b0, 1'b1, 1'b0, 2'd2},  // R4 write
      '{1'b0, 24'h200555, 1'b1, 1'b0, 1'b0, 26'h0210555, 1'b1, 1'b0, 1'b1, 2'd3},  // R6 flags
      '{1'b1, 24'h280FFF, 1'b0, 1'b0, 1'b1, 26'h0,       1'b0, 1'b0, 1'b0, 2'd0},  // R7 blocked
      '{1'b0, 24'h281000, 1'b0, 1'b1, 1'b0, 26'h0,       1'b0, 1'b0, 1'b0, 2'd0},  // R3 past stop
      '{1'b0, 24'h800000, 1'b0, 1'b1, 1'b0, 26'h0,       1'b0, 1'b0, 1'b0, 2'd0},  // R9 disabled
      '{1'b0, 24'hFFFFFF, 1'b1, 1'b0, 1'b0, 26'h3FFFFFF, 1'b1, 1'b0, 1'b0, 2'd0},  // R5 top page
      '{1'b1, 24'h17F000, 1'b1, 1'b0, 1'b0, 26'h007F000, 1'b0, 1'b1, 1'b0, 2'd2}   // R3 inside
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_check(input logic [7:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(reg_rdata == exp, req, "readback", 32'(reg_rdata), 32'(exp));
   endtask

   task automatic access(input vec_t v, input string req);
      @(negedge clk);
      host_req = 1'b1; host_wr = v.wr; host_addr = v.addr;
      @(negedge clk);
      host_req = 1'b0;
      check(card_strobe == v.strobe, req, "strobe", 32'(card_strobe), 32'(v.strobe));
      check(no_claim == v.miss, req, "no_claim", 32'(no_claim), 32'(v.miss));
      check(wr_blocked == v.blk, req, "wr_blocked", 32'(wr_blocked), 32'(v.blk));
      check(card_wr == (v.strobe && v.wr), req, "card_wr", 32'(card_wr), 32'(v.strobe && v.wr));
      if (v.strobe) begin
         check(card_addr == v.caddr, req, "card_addr", 32'(card_addr), 32'(v.caddr));
         check({card_attr, card_wide, card_zero_wait, card_waits} ==
               {v.attr, v.wide, v.zws, v.waits}, "R6", "flags",
               32'({card_attr, card_wide, card_zero_wait, card_waits}),
               32'({v.attr, v.wide, v.zws, v.waits}));
      end
      @(negedge clk);
      check({card_strobe, no_claim, wr_blocked} == 3'b000, "R8", "one-cycle outcome",
            32'({card_strobe, no_claim, wr_blocked}), 32'h0);
   endtask

   function automatic vec_t mk(input logic wr, input logic [23:0] a, input logic s,
                               input logic m, input logic b, input logic [25:0] ca,
                               input logic at, input logic wd, input logic z,
                               input logic [1:0] ws);
      vec_t v;
      v = '{wr, a, s, m, b, ca, at, wd, z, ws};
      return v;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_check(8'h06, 8'h00, "R1");
      reg_check(8'h11, 8'h00, "R1");
      reg_check(8'h35, 8'h00, "R1");
      access(mk(1'b0, 24'h000000, 1'b0, 1'b1, 1'b0, 26'h0, 1'b0, 1'b0, 1'b0, 2'd0), "R1");

      // program windows
      reg_write(8'h10, 8'h00); reg_write(8'h11, 8'h81);
      reg_write(8'h12, 8'hFF); reg_write(8'h13, 8'h81);
      reg_write(8'h14, 8'h00); reg_write(8'h15, 8'h3F);
      reg_write(8'h18, 8'h80); reg_write(8'h19, 8'h41);
      reg_write(8'h1A, 8'h80); reg_write(8'h1B, 8'hC2);
      reg_write(8'h1C, 8'h10); reg_write(8'h1D, 8'hC0);
      reg_write(8'h20, 8'h00); reg_write(8'h21, 8'hC8);
      reg_write(8'h22, 8'h00); reg_write(8'h23, 8'h48);
      reg_write(8'h24, 8'h34); reg_write(8'h25, 8'h12);
      reg_write(8'h30, 8'hFF); reg_write(8'h31, 8'h0F);
      reg_write(8'h32, 8'hFF); reg_write(8'h33, 8'h0F);
      reg_write(8'h34, 8'h00); reg_write(8'h35, 8'h70);
      reg_write(8'h06, 8'h13);

      // R2 readback
      reg_check(8'h11, 8'h81, "R2");
      reg_check(8'h15, 8'h3F, "R2");
      reg_check(8'h1D, 8'hC0, "R2");
      reg_check(8'h06, 8'h13, "R2");
      reg_check(8'h16, 8'h00, "R2");

      for (int i = 0; i < NVEC; i++) access(VECS[i], "R3/R4/R5/R7/R8/R9 vector");

      // R9 then enabling window 2: single-page window, inclusive
      reg_write(8'h06, 8'h17);
      access(mk(1'b0, 24'h800010, 1'b1, 1'b0, 1'b0, 26'h1A34010, 1'b0, 1'b1, 1'b1, 2'd1), "R9");
      access(mk(1'b0, 24'h801000, 1'b0, 1'b1, 1'b0, 26'h0, 1'b0, 1'b0, 1'b0, 2'd0), "R3");

      // R7 read of protected window strobes
      access(mk(1'b0, 24'h280FFF, 1'b1, 1'b0, 1'b0, 26'h0290FFF, 1'b1, 1'b0, 1'b1, 2'd3), "R7");

      // R4 with window 0 disabled the overlap goes to window 1
      reg_write(8'h06, 8'h12);
      access(mk(1'b0, 24'h180000, 1'b1, 1'b0, 1'b0, 26'h0190000, 1'b1, 1'b0, 1'b1, 2'd3), "R4");

      // R6 scratch bits read back, change nothing
      reg_write(8'h19, 8'h71);
      reg_check(8'h19, 8'h71, "R6");
      access(mk(1'b0, 24'h200555, 1'b1, 1'b0, 1'b0, 26'h0210555, 1'b1, 1'b0, 1'b1, 2'd3), "R6");

      // R2 enable bits above window count read 0
      reg_write(8'h06, 8'hFF);
      reg_check(8'h06, 8'h1F, "R2");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule